// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit carries out one atomic update of a memory location per request. A request gives a base register value, a signed 16-bit displacement, a source operand, the value of the comparison register R0, an access size and an 8-bit operation code. On a start strobe the unit raises a lock toward the memory arbiter. It then reads the addressed location, works out the new value and writes it back. After that it drops the lock and pulses done. With the done pulse it returns the value the location held before the update, zero-extended to the register width. It also says which register file entry (the source register or R0) should take that value.

The memory is a plain synchronous port with one cycle of read latency. It has one data word of register width and byte enables. A 32-bit access picks the lower or upper half of that word from address bit 2. Operation codes or sizes the unit does not support end at once with an error and done. They cause no memory traffic.

Top module: `atomic_rmw_unit`

## Requirements
- R1: Size code 2'b00 selects a 32-bit access and 2'b11 a 64-bit access. Codes 2'b01 and 2'b10 are rejected with error.
- R2: The byte address is base plus the 16-bit displacement sign-extended to the register width. mem_addr carries byte-address bits [MEM_AW+2:3]. For 32-bit accesses, byte-address bit 2 picks the upper half (mem_be 0xF0) or the lower half (0x0F). 64-bit accesses use mem_be 0xFF.
- R3: Op codes 0x00 (add), 0x40 (or), 0x50 (and) and 0xA0 (xor) combine the old value with the source operand and write the result. Add wraps at the access width, and a 32-bit write leaves the other half of the word unchanged.
- R4: Bit 0 of the op code requests fetch. With fetch set on add/or/and/xor/exchange, wb_src pulses with done. Without fetch, wb_src stays low. old_val always carries the pre-update value, zero-extended.
- R5: Op code 0xE1 (exchange) writes the source operand and returns the old value through wb_src.
- R6: Op code 0xF1 (compare-exchange) compares the old value with R0, using only the low 32 bits for a 32-bit access. On a match it writes the source operand; on a mismatch it performs no write. In both cases wb_r0 pulses with done, and wb_src stays low.
- R7: Any other op code (including 0xE0 and 0xF0), or a rejected size, gives error together with done one cycle after the start edge. There is no read, no write and no lock.
- R8: mem_rd is high in the first cycle after the start edge. mem_lock is high for three consecutive cycles starting there. mem_wr, when used, is high in the third of those cycles. done is high for exactly the fourth cycle, with the lock released.
- R9: A start strobe while a sequence is in progress is ignored.
- R10: During and right after reset, done, error, mem_lock, mem_rd, mem_wr, wb_src and wb_r0 are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled when idle |
| base_val | input | XLEN | Base register value |
| disp | input | OFF_W | Signed displacement |
| src_val | input | XLEN | Source operand |
| cmp_val | input | XLEN | R0 value for compare-exchange |
| size_code | input | 2 | Access size code |
| op_code | input | 8 | Atomic operation code |
| mem_addr | output | MEM_AW | Memory word address |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | XLEN | Read data, valid one cycle after mem_rd |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | XLEN | Write data |
| mem_be | output | XLEN/8 | Byte enables for the write |
| mem_lock | output | 1 | Held while the sequence owns memory |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Rejected request, valid with done |
| old_val | output | XLEN | Pre-update memory value, zero-extended |
| wb_src | output | 1 | old_val goes to the source register |
| wb_r0 | output | 1 | old_val goes to R0 |

## Verification
The bench builds the unit with MEM_AW = 16. The word address therefore reaches byte-address bit 18, so it exposes whether the displacement is sign- or zero-extended past bit 16. The memory model keeps only 16 words, indexed by the low four word-address bits, while the full mem_addr is compared against the expected value. The default XLEN of 64 keeps both the 32-bit lane paths and the 64-bit paths in play, including add wraparound in each width.

// File: rtl/atomic_pkg.sv
package atomic_pkg;

  typedef enum logic [2:0] {
    OP_ADD,
    OP_OR,
    OP_AND,
    OP_XOR,
    OP_XCHG,
    OP_CMPX
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_MODIFY,
    ST_WRITE,
    ST_DONE
  } state_e;

  typedef struct packed {
    op_e  op;
    logic fetch;
    logic wide;
    logic bad;
  } dec_t;

  localparam logic [7:0] CODE_ADD  = 8'h00;
  localparam logic [7:0] CODE_OR   = 8'h40;
  localparam logic [7:0] CODE_AND  = 8'h50;
  localparam logic [7:0] CODE_XOR  = 8'hA0;
  localparam logic [7:0] CODE_XCHG = 8'hE1;
  localparam logic [7:0] CODE_CMPX = 8'hF1;
  localparam logic [7:0] FETCH_BIT = 8'h01;

  localparam logic [1:0] SZ_WORD  = 2'b00;
  localparam logic [1:0] SZ_DWORD = 2'b11;

endpackage

// File: rtl/atomic_decode.sv
module atomic_decode
  import atomic_pkg::*;
(
  input  logic [7:0] op_code,
  input  logic [1:0] size_code,
  output dec_t       dec
);

  logic size_ok;

  always_comb begin
    size_ok   = (size_code == SZ_WORD) || (size_code == SZ_DWORD);
    dec       = '0;
    dec.op    = OP_ADD;
    dec.fetch = op_code[0];
    dec.wide  = (size_code == SZ_DWORD);
    dec.bad   = !size_ok;
    case (op_code)
      CODE_ADD, CODE_ADD | FETCH_BIT: dec.op = OP_ADD;
      CODE_OR,  CODE_OR  | FETCH_BIT: dec.op = OP_OR;
      CODE_AND, CODE_AND | FETCH_BIT: dec.op = OP_AND;
      CODE_XOR, CODE_XOR | FETCH_BIT: dec.op = OP_XOR;
      CODE_XCHG:                      dec.op = OP_XCHG;
      CODE_CMPX:                      dec.op = OP_CMPX;
      default:                        dec.bad = 1'b1;
    endcase
  end

endmodule

// File: rtl/atomic_addr_gen.sv
module atomic_addr_gen #(
  parameter int XLEN   = 64,
  parameter int OFF_W  = 16,
  parameter int MEM_AW = 10
) (
  input  logic [XLEN-1:0]   base_val,
  input  logic [OFF_W-1:0]  disp,
  output logic [MEM_AW-1:0] word_addr,
  output logic              upper_lane
);

  localparam int BE_W = XLEN / 8;
  localparam int WSH  = $clog2(BE_W);
  localparam int USED = WSH + MEM_AW;

  logic [XLEN-1:0] disp_ext;
  logic [USED-1:0] byte_addr;

  always_comb begin
    disp_ext   = {{(XLEN-OFF_W){disp[OFF_W-1]}}, disp};
    byte_addr  = base_val[USED-1:0] + disp_ext[USED-1:0];
    word_addr  = byte_addr[USED-1:WSH];
    upper_lane = byte_addr[WSH-1];
  end

endmodule

// File: rtl/atomic_alu.sv
module atomic_alu
  import atomic_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  dec_t              dec,
  input  logic              upper_lane,
  input  logic [XLEN-1:0]   rdata,
  input  logic [XLEN-1:0]   src_val,
  input  logic [XLEN-1:0]   cmp_val,
  output logic [XLEN-1:0]   old_ext,
  output logic [XLEN-1:0]   wdata,
  output logic [XLEN/8-1:0] be,
  output logic              do_write
);

  localparam int HALF = XLEN / 2;
  localparam int BE_W = XLEN / 8;

  logic [HALF-1:0] half_sel;
  logic [XLEN-1:0] result;
  logic            match;
  logic [BE_W-1:0] be_lo;
  logic [BE_W-1:0] be_hi;

  generate
    if (BE_W > 1) begin : g_lanes
      assign be_lo = {{(BE_W/2){1'b0}}, {(BE_W/2){1'b1}}};
      assign be_hi = {{(BE_W/2){1'b1}}, {(BE_W/2){1'b0}}};
    end else begin : g_single
      assign be_lo = '1;
      assign be_hi = '1;
    end
  endgenerate

  always_comb begin
    half_sel = upper_lane ? rdata[XLEN-1:HALF] : rdata[HALF-1:0];
    old_ext  = dec.wide ? rdata : {{HALF{1'b0}}, half_sel};
    match    = dec.wide ? (old_ext == cmp_val)
                        : (old_ext[HALF-1:0] == cmp_val[HALF-1:0]);
    case (dec.op)
      OP_ADD:  result = old_ext + src_val;
      OP_OR:   result = old_ext | src_val;
      OP_AND:  result = old_ext & src_val;
      OP_XOR:  result = old_ext ^ src_val;
      default: result = src_val;
    endcase
    do_write = !((dec.op == OP_CMPX) && !match);
    wdata    = dec.wide ? result : {result[HALF-1:0], result[HALF-1:0]};
    be       = dec.wide ? '1 : (upper_lane ? be_hi : be_lo);
  end

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atomic_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int OFF_W  = 16,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [XLEN-1:0]   base_val,
  input  logic [OFF_W-1:0]  disp,
  input  logic [XLEN-1:0]   src_val,
  input  logic [XLEN-1:0]   cmp_val,
  input  logic [1:0]        size_code,
  input  logic [7:0]        op_code,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              mem_wr,
  output logic [XLEN-1:0]   mem_wdata,
  output logic [XLEN/8-1:0] mem_be,
  output logic              mem_lock,
  output logic              done,
  output logic              error,
  output logic [XLEN-1:0]   old_val,
  output logic              wb_src,
  output logic              wb_r0
);

  localparam int BE_W = XLEN / 8;

  state_e            st_q, st_nxt;
  dec_t              dec_in, dec_q;
  logic [MEM_AW-1:0] waddr_in, addr_q;
  logic              lane_in, lane_q;
  logic [XLEN-1:0]   src_q, cmp_q;
  logic [XLEN-1:0]   alu_old, alu_wdata;
  logic [BE_W-1:0]   alu_be;
  logic              alu_wr;
  logic              rd_q, wr_q, lock_q, done_q, err_q, wbs_q, wbr_q;
  logic [XLEN-1:0]   old_q, wdata_q;
  logic [BE_W-1:0]   be_q;

  atomic_decode u_dec (
    .op_code   (op_code),
    .size_code (size_code),
    .dec       (dec_in)
  );

  atomic_addr_gen #(
    .XLEN   (XLEN),
    .OFF_W  (OFF_W),
    .MEM_AW (MEM_AW)
  ) u_addr (
    .base_val   (base_val),
    .disp       (disp),
    .word_addr  (waddr_in),
    .upper_lane (lane_in)
  );

  atomic_alu #(
    .XLEN (XLEN)
  ) u_alu (
    .dec        (dec_q),
    .upper_lane (lane_q),
    .rdata      (mem_rdata),
    .src_val    (src_q),
    .cmp_val    (cmp_q),
    .old_ext    (alu_old),
    .wdata      (alu_wdata),
    .be         (alu_be),
    .do_write   (alu_wr)
  );

  always_comb begin
    st_nxt = st_q;
    case (st_q)
      ST_IDLE:   if (start) st_nxt = dec_in.bad ? ST_DONE : ST_READ;
      ST_READ:   st_nxt = ST_MODIFY;
      ST_MODIFY: st_nxt = ST_WRITE;
      ST_WRITE:  st_nxt = ST_DONE;
      ST_DONE:   st_nxt = ST_IDLE;
      default:   st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      dec_q  <= '0;
      addr_q <= '0;
      lane_q <= 1'b0;
      src_q  <= '0;
      cmp_q  <= '0;
    end else begin
      st_q <= st_nxt;
      if (st_q == ST_IDLE && start) begin
        dec_q  <= dec_in;
        addr_q <= waddr_in;
        lane_q <= lane_in;
        src_q  <= src_val;
        cmp_q  <= cmp_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      old_q   <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (st_q == ST_MODIFY) begin
      old_q   <= alu_old;
      wdata_q <= alu_wdata;
      be_q    <= alu_be;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      lock_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      wbs_q  <= 1'b0;
      wbr_q  <= 1'b0;
    end else begin
      rd_q   <= (st_nxt == ST_READ);
      wr_q   <= (st_nxt == ST_WRITE) && alu_wr;
      lock_q <= (st_nxt == ST_READ) || (st_nxt == ST_MODIFY) ||
                (st_nxt == ST_WRITE);
      done_q <= (st_nxt == ST_DONE);
      err_q  <= (st_q == ST_IDLE) && (st_nxt == ST_DONE);
      wbs_q  <= (st_q == ST_WRITE) && dec_q.fetch && (dec_q.op != OP_CMPX);
      wbr_q  <= (st_q == ST_WRITE) && (dec_q.op == OP_CMPX);
    end
  end

  assign mem_addr  = addr_q;
  assign mem_rd    = rd_q;
  assign mem_wr    = wr_q;
  assign mem_wdata = wdata_q;
  assign mem_be    = be_q;
  assign mem_lock  = lock_q;
  assign done      = done_q;
  assign error     = err_q;
  assign old_val   = old_q;
  assign wb_src    = wbs_q;
  assign wb_r0     = wbr_q;

endmodule

// File: rtl/atomic_rmw_checker.sv
module atomic_rmw_checker #(
  parameter int BE_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic            mem_lock,
  input logic            done,
  input logic            error,
  input logic            wb_src,
  input logic            wb_r0,
  input logic [BE_W-1:0] mem_be
);

  localparam logic [BE_W-1:0] BE_ALL = '1;
  localparam logic [BE_W-1:0] BE_LO  = {{(BE_W/2){1'b0}}, {(BE_W/2){1'b1}}};
  localparam logic [BE_W-1:0] BE_HI  = {{(BE_W/2){1'b1}}, {(BE_W/2){1'b0}}};

  assert_lock_on_read_R8: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> mem_lock);

  assert_modify_after_read_R8: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> (mem_lock && !mem_rd && !mem_wr));

  assert_lock_on_write_R8: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> mem_lock);

  assert_done_after_write_R8: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> (done && !mem_lock));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_error_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    error |-> (done && !mem_lock && !wb_src && !wb_r0));

  assert_r0_only_R6: assert property (@(posedge clk) disable iff (rst)
    wb_r0 |-> (done && !wb_src));

  assert_fetch_with_done_R4: assert property (@(posedge clk) disable iff (rst)
    wb_src |-> done);

  assert_lane_mask_R2: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (mem_be == BE_ALL || mem_be == BE_LO || mem_be == BE_HI));

endmodule

bind atomic_rmw_unit atomic_rmw_checker #(.BE_W(BE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .mem_lock (mem_lock),
  .done     (done),
  .error    (error),
  .wb_src   (wb_src),
  .wb_r0    (wb_r0),
  .mem_be   (mem_be)
);

// File: tb/sim_atomic_rmw_unit.sv
`timescale 1ns/1ps
module sim_atomic_rmw_unit;

  localparam int XLEN   = 64;
  localparam int OFF_W  = 16;
  localparam int MEM_AW = 16;
  localparam int NV     = 15;

  typedef struct packed {
    logic [7:0]  op;
    logic [1:0]  sz;
    logic [63:0] base;
    logic [15:0] off;
    logic [63:0] src;
    logic [63:0] r0;
    logic [63:0] init;
    logic [63:0] exp_mem;
    logic [63:0] exp_old;
    logic        exp_wbs;
    logic        exp_wbr;
    logic        exp_err;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{8'h00, 2'b11, 64'h10, 16'h0000, 64'h2, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF,
      64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b0},
    '{8'h01, 2'b00, 64'h20, 16'h0000, 64'h3, 64'h0, 64'h1111_1111_FFFF_FFFF,
      64'h1111_1111_0000_0002, 64'h0000_0000_FFFF_FFFF, 1'b1, 1'b0, 1'b0},
    '{8'h41, 2'b00, 64'h40, 16'hFFFC, 64'h0F0F_0F0F, 64'h0, 64'hA0A0_A0A0_5555_5555,
      64'hAFAF_AFAF_5555_5555, 64'h0000_0000_A0A0_A0A0, 1'b1, 1'b0, 1'b0},
    '{8'h50, 2'b11, 64'h30, 16'h0008, 64'h0FF0_0FF0_0FF0_0FF0, 64'h0, 64'hFF00_FF00_FF00_FF00,
      64'h0F00_0F00_0F00_0F00, 64'hFF00_FF00_FF00_FF00, 1'b0, 1'b0, 1'b0},
    '{8'hA1, 2'b11, 64'h0, 16'h0018, 64'hFFFF_FFFF_0000_0000, 64'h0, 64'h1234_5678_9ABC_DEF0,
      64'hEDCB_A987_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 1'b1, 1'b0, 1'b0},
    '{8'hE1, 2'b00, 64'h8, 16'h0000, 64'h5555_5555_1234_5678, 64'h0, 64'hDEAD_BEEF_CAFE_F00D,
      64'hDEAD_BEEF_1234_5678, 64'h0000_0000_CAFE_F00D, 1'b1, 1'b0, 1'b0},
    '{8'hE1, 2'b11, 64'h50, 16'h0000, 64'hAAAA_BBBB_CCCC_DDDD, 64'h0, 64'h1,
      64'hAAAA_BBBB_CCCC_DDDD, 64'h1, 1'b1, 1'b0, 1'b0},
    '{8'hF1, 2'b11, 64'h60, 16'h0000, 64'h99, 64'h77, 64'h77,
      64'h99, 64'h77, 1'b0, 1'b1, 1'b0},
    '{8'hF1, 2'b11, 64'h60, 16'h0000, 64'h99, 64'h78, 64'h77,
      64'h77, 64'h77, 1'b0, 1'b1, 1'b0},
    '{8'hF1, 2'b00, 64'h64, 16'h0000, 64'h1234_5678_0000_0009, 64'hFFFF_FFFF_0000_0042,
      64'h0000_0042_0000_0005, 64'h0000_0009_0000_0005, 64'h42, 1'b0, 1'b1, 1'b0},
    '{8'hE0, 2'b11, 64'h70, 16'h0000, 64'h9, 64'h0, 64'h5,
      64'h5, 64'h0, 1'b0, 1'b0, 1'b1},
    '{8'h00, 2'b10, 64'h78, 16'h0000, 64'h9, 64'h0, 64'h6,
      64'h6, 64'h0, 1'b0, 1'b0, 1'b1},
    '{8'hA0, 2'b01, 64'h78, 16'h0000, 64'h9, 64'h0, 64'h6,
      64'h6, 64'h0, 1'b0, 1'b0, 1'b1},
    '{8'h02, 2'b11, 64'h70, 16'h0000, 64'h9, 64'h0, 64'h5,
      64'h5, 64'h0, 1'b0, 1'b0, 1'b1},
    '{8'h01, 2'b11, 64'h1_0008, 16'hFFF8, 64'h5, 64'h0, 64'hA,
      64'hF, 64'hA, 1'b1, 1'b0, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [XLEN-1:0]   base_val = '0;
  logic [OFF_W-1:0]  disp = '0;
  logic [XLEN-1:0]   src_val = '0;
  logic [XLEN-1:0]   cmp_val = '0;
  logic [1:0]        size_code = '0;
  logic [7:0]        op_code = '0;
  logic [MEM_AW-1:0] mem_addr;
  logic              mem_rd;
  logic [XLEN-1:0]   mem_rdata = '0;
  logic              mem_wr;
  logic [XLEN-1:0]   mem_wdata;
  logic [7:0]        mem_be;
  logic              mem_lock;
  logic              done;
  logic              error;
  logic [XLEN-1:0]   old_val;
  logic              wb_src;
  logic              wb_r0;

  logic [63:0] mem [16];
  logic        pl_en = 1'b0;
  logic [3:0]  pl_idx = '0;
  logic [63:0] pl_data = '0;

  int n_checks = 0;
  int n_fail   = 0;

  int          rd_cnt, wr_cnt, lock_cnt, done_cnt, rd_seen, wr_seen, done_seen;
  logic [15:0] rd_addr;
  logic        lock_at_done, r_err, r_wbs, r_wbr;
  logic [63:0] r_old;

  always #10 clk = ~clk;

  atomic_rmw_unit #(.XLEN(XLEN), .OFF_W(OFF_W), .MEM_AW(MEM_AW)) u0 (
    .clk(clk), .rst(rst), .start(start), .base_val(base_val), .disp(disp),
    .src_val(src_val), .cmp_val(cmp_val), .size_code(size_code), .op_code(op_code),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_lock(mem_lock), .done(done),
    .error(error), .old_val(old_val), .wb_src(wb_src), .wb_r0(wb_r0)
  );

  always @(posedge clk) begin
    if (pl_en) mem[pl_idx] <= pl_data;
    if (mem_rd) mem_rdata <= mem[mem_addr[3:0]];
    if (mem_wr) begin
      for (int b = 0; b < 8; b++)
        if (mem_be[b]) mem[mem_addr[3:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
  end

  function automatic logic [15:0] exp_waddr(input logic [63:0] b, input logic [15:0] o);
    logic [63:0] a;
    a = b + {{48{o[15]}}, o};
    return a[18:3];
  endfunction

  task automatic check(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic preload(input logic [3:0] idx, input logic [63:0] d);
    @(negedge clk);
    pl_en = 1'b1; pl_idx = idx; pl_data = d;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  task automatic run_op(input logic [7:0] op, input logic [1:0] sz, input logic [63:0] b,
                        input logic [15:0] o, input logic [63:0] s, input logic [63:0] r);
    int cnt;
    @(negedge clk);
    op_code = op; size_code = sz; base_val = b; disp = o; src_val = s; cmp_val = r;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rd_cnt = 0; wr_cnt = 0; lock_cnt = 0; done_cnt = 0; rd_seen = 0; wr_seen = 0;
    done_seen = 0; rd_addr = '0; lock_at_done = 1'b0;
    r_err = 1'b0; r_wbs = 1'b0; r_wbr = 1'b0; r_old = '0;
    cnt = 1;
    while (done_seen == 0 && cnt < 12) begin
      if (mem_rd) begin rd_seen++; rd_cnt = cnt; rd_addr = mem_addr; end
      if (mem_wr) begin wr_seen++; wr_cnt = cnt; end
      if (mem_lock) lock_cnt++;
      if (done) begin
        done_seen = 1; done_cnt = cnt; lock_at_done = mem_lock;
        r_err = error; r_wbs = wb_src; r_wbr = wb_r0; r_old = old_val;
      end else begin
        @(negedge clk);
        cnt++;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs quiet during reset
    check(!done && !error && !mem_lock && !mem_rd && !mem_wr && !wb_src && !wb_r0,
          "R10 outputs during reset", {57'b0, done, error, mem_lock, mem_rd, mem_wr, wb_src, wb_r0}, 64'h0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!done && !error && !mem_lock && !mem_rd && !mem_wr && !wb_src && !wb_r0,
          "R10 outputs after reset", {57'b0, done, error, mem_lock, mem_rd, mem_wr, wb_src, wb_r0}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  widx;
      logic [15:0] ea;
      ea   = exp_waddr(VECS[i].base, VECS[i].off);
      widx = ea[3:0];
      preload(widx, VECS[i].init);
      run_op(VECS[i].op, VECS[i].sz, VECS[i].base, VECS[i].off, VECS[i].src, VECS[i].r0);
      check(done_seen == 1, $sformatf("R8 vector %0d done seen", i), 64'(done_seen), 64'd1);
      check(mem[widx] == VECS[i].exp_mem, $sformatf("R3/R5/R6 vector %0d memory", i),
            mem[widx], VECS[i].exp_mem);
      check(r_err == VECS[i].exp_err, $sformatf("R1/R7 vector %0d error", i),
            64'(r_err), 64'(VECS[i].exp_err));
      check(r_wbs == VECS[i].exp_wbs, $sformatf("R4 vector %0d wb_src", i),
            64'(r_wbs), 64'(VECS[i].exp_wbs));
      check(r_wbr == VECS[i].exp_wbr, $sformatf("R6 vector %0d wb_r0", i),
            64'(r_wbr), 64'(VECS[i].exp_wbr));
      if (VECS[i].exp_err) begin
        check(rd_seen == 0 && wr_seen == 0 && lock_cnt == 0,
              $sformatf("R7 vector %0d no traffic", i), 64'(rd_seen + wr_seen + lock_cnt), 64'd0);
      end else begin
        check(r_old == VECS[i].exp_old, $sformatf("R4 vector %0d old_val", i),
              r_old, VECS[i].exp_old);
        check(rd_addr == ea, $sformatf("R2 vector %0d word address", i),
              64'(rd_addr), 64'(ea));
      end
    end

    // R8: cycle placement of read, lock, write and done
    preload(4'd9, 64'h100);
    run_op(8'h00, 2'b11, 64'h48, 16'h0, 64'h1, 64'h0);
    check(rd_cnt == 1, "R8 read cycle", 64'(rd_cnt), 64'd1);
    check(lock_cnt == 3, "R8 lock length", 64'(lock_cnt), 64'd3);
    check(wr_cnt == 3, "R8 write cycle", 64'(wr_cnt), 64'd3);
    check(done_cnt == 4 && !lock_at_done, "R8 done cycle", 64'(done_cnt), 64'd4);

    // R6: mismatch performs no write strobe
    preload(4'd9, 64'h100);
    run_op(8'hF1, 2'b11, 64'h48, 16'h0, 64'h5, 64'h101);
    check(wr_seen == 0 && done_cnt == 4, "R6 mismatch no write", 64'(wr_seen), 64'd0);

    // R7: rejected request timing
    run_op(8'hF0, 2'b11, 64'h48, 16'h0, 64'h5, 64'h100);
    check(done_cnt == 1 && r_err, "R7 error done timing", 64'(done_cnt), 64'd1);

    // R9: start during a sequence is ignored
    preload(4'd5, 64'd100);
    preload(4'd6, 64'd200);
    @(negedge clk);
    op_code = 8'h00; size_code = 2'b11; base_val = 64'h28; disp = '0; src_val = 64'd1;
    start = 1'b1;
    @(negedge clk);
    base_val = 64'h30; src_val = 64'd7;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    begin
      int dn;
      dn = 0;
      for (int c = 0; c < 8; c++) begin
        if (done) dn++;
        @(negedge clk);
      end
      check(dn == 1, "R9 single done", 64'(dn), 64'd1);
    end
    check(mem[5] == 64'd101, "R9 first op applied", mem[5], 64'd101);
    check(mem[6] == 64'd200, "R9 second start ignored", mem[6], 64'd200);

    finish_run();
  end

endmodule